// File: doc/BRIEF.md
# Key-Protected Access Lock Controller

This block decides whether the read, write, verify and erase commands of a configuration memory may proceed. A key is loaded one bit at a time through a shift-in path of the kind a test-port data register provides. The block holds a programmed key in a nonvolatile vault and compares a candidate against it only on an explicit update pulse. It tracks four conditions: no key programmed, locked, unlocked and permanently fused. It drives one enable per operation, a two-bit status word, and a registered command path to the memory.

A permanent-lock command destroys the stored key and sets a fuse. After that, no candidate opens the device, the correct key included. Every command is then refused for good, across resets. Operation requests that reach the block while their enable is low never reach the memory. Each one raises a single-cycle denial pulse instead.

Top module: `key_lock_ctrl`

## Requirements
- R1: With no key programmed, status is 00 and all four operation enables are high. Every request is forwarded, and update pulses have no effect.
- R2: Candidate bits enter on `key_bit` whenever `key_shift_en` is high, least significant bit first. The key width is the parameter `KEY_W`, default 79. A key shifted in reverse order does not match.
- R3: A `key_prog` pulse with no key programmed stores the shifted-in candidate as the key. On the next cycle the status is 01 (locked).
- R4: While locked, all operation enables are low and every request is denied.
- R5: An update pulse in the locked state, with no shift strobe in the same cycle, compares the candidate against the stored key. On a match the status becomes 10 (unlocked) and all enables rise. An update that coincides with a shift strobe does not compare.
- R6: A compared candidate that does not match leaves the status at 01. Any compare clears the candidate register, so bits shifted in before a rejected update never join a later candidate.
- R7: A `lock_cmd` pulse while unlocked returns the status to 01.
- R8: A `perm_lock_cmd` pulse is honoured only while locked or unlocked, and then moves the status to 11. With no key programmed, it is ignored.
- R9: Once the status is 11, it stays 11. No key, lock command or programming pulse opens any enable.
- R10: Reset (synchronous, active high) leaves the key and the fuse intact. The status comes back as 11 if fused, as 01 if a key is programmed, and as 00 otherwise.
- R11: Operation codes are 00 read, 01 write, 10 verify and 11 erase, and enable bit n belongs to code n. A request whose enable is high shows up on the next cycle as `mem_op_valid` with the same code. A request whose enable is low instead gives a one-cycle `access_denied` pulse on the next cycle, with `mem_op_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_shift_en | input | 1 | Shift strobe for the candidate register |
| key_bit | input | 1 | Serial candidate bit |
| key_update | input | 1 | Compare strobe |
| key_prog | input | 1 | Store the candidate as the key (no key programmed only) |
| lock_cmd | input | 1 | Relock from the unlocked state |
| perm_lock_cmd | input | 1 | Destroy the key and fuse the device |
| op_req_valid | input | 1 | Operation request strobe |
| op_req_kind | input | 2 | Operation code |
| op_en | output | 4 | Per-operation enables |
| status | output | 2 | 00 no key, 01 locked, 10 unlocked, 11 fused |
| mem_op_valid | output | 1 | Forwarded command strobe |
| mem_op_kind | output | 2 | Forwarded operation code |
| access_denied | output | 1 | One-cycle refusal pulse |

## Verification
The compare is driven with several candidates, and each one separates a different fault. The exact key must open the block. A key with one bit flipped must not. The same key shifted most significant bit first must not, which exposes a wrong shift direction. A key whose first bit comes before a rejected update and whose other bits come after it must not, which exposes a candidate register left uncleared. A final-bit shift that coincides with the update separates a block that compares during shifting from one that waits for a quiet update. The same table of request codes is walked in every state, which tells the no-key, locked, unlocked and fused gating apart.

// File: rtl/key_lock_pkg.sv
package key_lock_pkg;
  typedef enum logic [1:0] {
    ST_OPEN     = 2'b00,
    ST_LOCKED   = 2'b01,
    ST_UNLOCKED = 2'b10,
    ST_FUSED    = 2'b11
  } lock_state_t;

  localparam int DEF_KEY_W = 79;
  localparam int DEF_N_OPS = 4;
endpackage

// File: rtl/key_shift_reg.sv
module key_shift_reg #(
  parameter int KEY_W = 79
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_en,
  input  logic             bit_in,
  input  logic             clear,
  output logic [KEY_W-1:0] cand
);
  logic [KEY_W-1:0] sr_q;

  // New bits enter at the top so the first bit ends at position 0.
  always_ff @(posedge clk) begin
    if (rst || clear) begin
      sr_q <= '0;
    end else if (shift_en) begin
      sr_q <= {bit_in, sr_q[KEY_W-1:1]};
    end
  end

  assign cand = sr_q;
endmodule

// File: rtl/key_vault.sv
module key_vault #(
  parameter int KEY_W = 79
) (
  input  logic             clk,
  input  logic             prog_we,
  input  logic [KEY_W-1:0] prog_data,
  input  logic             destroy,
  input  logic [KEY_W-1:0] cand,
  output logic             key_set,
  output logic             fused,
  output logic             match
);
  // Nonvolatile contents: power-up values only, untouched by reset.
  logic [KEY_W-1:0] key_q     = '0;
  logic             key_set_q = 1'b0;
  logic             fused_q   = 1'b0;

  always_ff @(posedge clk) begin
    if (destroy) begin
      key_q   <= '0;
      fused_q <= 1'b1;
    end else if (prog_we && !fused_q) begin
      key_q     <= prog_data;
      key_set_q <= 1'b1;
    end
  end

  assign key_set = key_set_q;
  assign fused   = fused_q;
  assign match   = key_set_q && !fused_q && (cand == key_q);
endmodule

// File: rtl/lock_fsm.sv
module lock_fsm
  import key_lock_pkg::*;
#(
  parameter int N_OPS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             key_set,
  input  logic             fused,
  input  logic             match,
  input  logic             shift_en,
  input  logic             update,
  input  logic             prog_cmd,
  input  logic             lock_cmd,
  input  logic             perm_cmd,
  output lock_state_t      state,
  output logic [N_OPS-1:0] en,
  output logic             prog_we,
  output logic             destroy,
  output logic             clear_cand
);
  lock_state_t      state_q, state_d, reset_state;
  logic [N_OPS-1:0] en_q;
  logic             upd_ok;
  logic             secured;

  function automatic logic [N_OPS-1:0] en_of(input lock_state_t s);
    if (s == ST_OPEN || s == ST_UNLOCKED) return {N_OPS{1'b1}};
    return '0;
  endfunction

  assign upd_ok     = update && !shift_en;
  assign secured    = (state_q == ST_LOCKED) || (state_q == ST_UNLOCKED);
  assign prog_we    = !rst && (state_q == ST_OPEN) && prog_cmd;
  assign destroy    = !rst && secured && perm_cmd;
  assign clear_cand = upd_ok || prog_we;

  always_comb begin
    if (fused)        reset_state = ST_FUSED;
    else if (key_set) reset_state = ST_LOCKED;
    else              reset_state = ST_OPEN;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OPEN:     if (prog_cmd) state_d = ST_LOCKED;
      ST_LOCKED: begin
        if (perm_cmd)             state_d = ST_FUSED;
        else if (upd_ok && match) state_d = ST_UNLOCKED;
      end
      ST_UNLOCKED: begin
        if (perm_cmd)      state_d = ST_FUSED;
        else if (lock_cmd) state_d = ST_LOCKED;
      end
      ST_FUSED:    state_d = ST_FUSED;
      default:     state_d = ST_FUSED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= reset_state;
      en_q    <= en_of(reset_state);
    end else begin
      state_q <= state_d;
      en_q    <= en_of(state_d);
    end
  end

  assign state = state_q;
  assign en    = en_q;
endmodule

// File: rtl/op_gate.sv
module op_gate #(
  parameter int N_OPS = 4,
  parameter int OP_W  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_OPS-1:0] en,
  input  logic             req_valid,
  input  logic [OP_W-1:0]  req_kind,
  output logic             mem_valid,
  output logic [OP_W-1:0]  mem_kind,
  output logic             denied
);
  logic            valid_q, denied_q;
  logic [OP_W-1:0] kind_q;
  logic            allowed;

  assign allowed = en[req_kind];

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q  <= 1'b0;
      denied_q <= 1'b0;
      kind_q   <= '0;
    end else begin
      valid_q  <= req_valid && allowed;
      denied_q <= req_valid && !allowed;
      if (req_valid && allowed) kind_q <= req_kind;
    end
  end

  assign mem_valid = valid_q;
  assign mem_kind  = kind_q;
  assign denied    = denied_q;
endmodule

// File: rtl/key_lock_ctrl.sv
module key_lock_ctrl
  import key_lock_pkg::*;
#(
  parameter int KEY_W = DEF_KEY_W,
  parameter int N_OPS = DEF_N_OPS,
  localparam int OP_W = $clog2(N_OPS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             key_shift_en,
  input  logic             key_bit,
  input  logic             key_update,
  input  logic             key_prog,
  input  logic             lock_cmd,
  input  logic             perm_lock_cmd,
  input  logic             op_req_valid,
  input  logic [OP_W-1:0]  op_req_kind,
  output logic [N_OPS-1:0] op_en,
  output logic [1:0]       status,
  output logic             mem_op_valid,
  output logic [OP_W-1:0]  mem_op_kind,
  output logic             access_denied
);
  logic [KEY_W-1:0] cand;
  logic             key_set, fused, match;
  logic             prog_we, destroy, clear_cand;
  lock_state_t      state;

  key_shift_reg #(.KEY_W(KEY_W)) u_shift (
    .clk(clk), .rst(rst), .shift_en(key_shift_en), .bit_in(key_bit),
    .clear(clear_cand), .cand(cand)
  );

  key_vault #(.KEY_W(KEY_W)) u_vault (
    .clk(clk), .prog_we(prog_we), .prog_data(cand), .destroy(destroy),
    .cand(cand), .key_set(key_set), .fused(fused), .match(match)
  );

  lock_fsm #(.N_OPS(N_OPS)) u_fsm (
    .clk(clk), .rst(rst), .key_set(key_set), .fused(fused), .match(match),
    .shift_en(key_shift_en), .update(key_update), .prog_cmd(key_prog),
    .lock_cmd(lock_cmd), .perm_cmd(perm_lock_cmd), .state(state),
    .en(op_en), .prog_we(prog_we), .destroy(destroy), .clear_cand(clear_cand)
  );

  op_gate #(.N_OPS(N_OPS), .OP_W(OP_W)) u_gate (
    .clk(clk), .rst(rst), .en(op_en), .req_valid(op_req_valid),
    .req_kind(op_req_kind), .mem_valid(mem_op_valid), .mem_kind(mem_op_kind),
    .denied(access_denied)
  );

  assign status = state;
endmodule

// File: rtl/key_lock_ctrl_checker.sv
module key_lock_ctrl_checker #(
  parameter int N_OPS = 4,
  parameter int OP_W  = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             key_shift_en,
  input logic             key_update,
  input logic             key_prog,
  input logic             lock_cmd,
  input logic             perm_lock_cmd,
  input logic             op_req_valid,
  input logic [OP_W-1:0]  op_req_kind,
  input logic [N_OPS-1:0] op_en,
  input logic [1:0]       status,
  input logic             mem_op_valid,
  input logic [OP_W-1:0]  mem_op_kind,
  input logic             access_denied
);
  p_open_all_r1: assert property (@(posedge clk) disable iff (rst)
    (status == 2'b00) |-> (&op_en));

  p_prog_locks_r3: assert property (@(posedge clk) disable iff (rst)
    (status == 2'b00 && key_prog) |=> (status == 2'b01));

  p_locked_closed_r4: assert property (@(posedge clk) disable iff (rst)
    (status == 2'b01) |-> (op_en == '0));

  p_unlock_needs_update_r5: assert property (@(posedge clk) disable iff (rst)
    (status == 2'b01 && !(key_update && !key_shift_en)) |=> (status != 2'b10));

  p_relock_r7: assert property (@(posedge clk) disable iff (rst)
    (status == 2'b10 && lock_cmd && !perm_lock_cmd) |=> (status == 2'b01));

  p_fused_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (status == 2'b11) |=> (status == 2'b11 && op_en == '0));

  p_deny_gate_r11: assert property (@(posedge clk) disable iff (rst)
    (op_req_valid && !op_en[op_req_kind]) |=> (access_denied && !mem_op_valid));

  p_pass_gate_r11: assert property (@(posedge clk) disable iff (rst)
    (op_req_valid && op_en[op_req_kind]) |=>
      (mem_op_valid && !access_denied && mem_op_kind == $past(op_req_kind)));

  p_quiet_gate_r11: assert property (@(posedge clk) disable iff (rst)
    !op_req_valid |=> (!mem_op_valid && !access_denied));
endmodule

bind key_lock_ctrl key_lock_ctrl_checker #(.N_OPS(N_OPS), .OP_W(OP_W)) u_chk (
  .clk(clk), .rst(rst), .key_shift_en(key_shift_en), .key_update(key_update),
  .key_prog(key_prog), .lock_cmd(lock_cmd), .perm_lock_cmd(perm_lock_cmd),
  .op_req_valid(op_req_valid), .op_req_kind(op_req_kind), .op_en(op_en),
  .status(status), .mem_op_valid(mem_op_valid), .mem_op_kind(mem_op_kind),
  .access_denied(access_denied)
);

// File: tb/key_lock_ctrl_bench.sv
module key_lock_ctrl_bench;
  localparam int KW = 79;
  localparam logic [KW-1:0] KEY_A = 79'h51D3C96E20B7F4A81C5;
  localparam logic [KW-1:0] KEY_BAD = KEY_A ^ (79'h1 << 40);
  // {valid, kind}
  localparam logic [2:0] REQ_TBL [8] = '{3'b100, 3'b101, 3'b110, 3'b111,
                                         3'b000, 3'b011, 3'b110, 3'b101};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic key_shift_en = 0, key_bit = 0, key_update = 0, key_prog = 0;
  logic lock_cmd = 0, perm_lock_cmd = 0, op_req_valid = 0;
  logic [1:0] op_req_kind = 0;
  logic [3:0] op_en;
  logic [1:0] status;
  logic mem_op_valid, access_denied;
  logic [1:0] mem_op_kind;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  key_lock_ctrl u_key_lock_ctrl (
    .clk(clk), .rst(rst), .key_shift_en(key_shift_en), .key_bit(key_bit),
    .key_update(key_update), .key_prog(key_prog), .lock_cmd(lock_cmd),
    .perm_lock_cmd(perm_lock_cmd), .op_req_valid(op_req_valid),
    .op_req_kind(op_req_kind), .op_en(op_en), .status(status),
    .mem_op_valid(mem_op_valid), .mem_op_kind(mem_op_kind),
    .access_denied(access_denied)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic shift_bits(input logic [KW-1:0] k, input int lo, input int hi);
    for (int i = lo; i <= hi; i++) begin
      key_bit = k[i]; key_shift_en = 1; tick();
    end
    key_shift_en = 0;
  endtask

  task automatic pulse_update();
    key_update = 1; tick(); key_update = 0;
  endtask

  task automatic run_table(input logic open, input string tag);
    for (int i = 0; i < 8; i++) begin
      op_req_valid = REQ_TBL[i][2]; op_req_kind = REQ_TBL[i][1:0];
      tick();
      op_req_valid = 0;
      check({tag, " R11 valid"}, mem_op_valid, REQ_TBL[i][2] && open);
      check({tag, " R11 denied"}, access_denied, REQ_TBL[i][2] && !open);
      if (REQ_TBL[i][2] && open) check({tag, " R11 kind"}, mem_op_kind, REQ_TBL[i][1:0]);
      tick();
      check({tag, " R11 one-cycle"}, {mem_op_valid, access_denied}, 2'b00);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    tick(); tick(); rst = 0;
    check("R1/R10 reset status", status, 2'b00);
    check("R1 enables", op_en, 4'hF);
    run_table(1, "R1");
    perm_lock_cmd = 1; tick(); perm_lock_cmd = 0;
    check("R8 perm ignored unsecured", status, 2'b00);
    pulse_update();
    check("R1 update ignored", status, 2'b00);

    shift_bits(KEY_A, 0, KW-1);
    key_prog = 1; tick(); key_prog = 0;
    check("R3 status locked", status, 2'b01);
    check("R4 enables low", op_en, 4'h0);
    run_table(0, "R4");

    shift_bits(KEY_BAD, 0, KW-1); pulse_update();
    check("R6 wrong key", status, 2'b01);
    shift_bits(KEY_A, 0, 0); pulse_update();
    shift_bits(KEY_A, 1, KW-1); pulse_update();
    check("R6 candidate cleared", status, 2'b01);
    for (int i = 0; i < KW; i++) begin
      key_bit = KEY_A[KW-1-i]; key_shift_en = 1; tick();
    end
    key_shift_en = 0; pulse_update();
    check("R2 msb-first rejected", status, 2'b01);

    shift_bits(KEY_A, 0, KW-1); pulse_update();
    check("R2/R5 unlocked", status, 2'b10);
    check("R5 enables", op_en, 4'hF);
    run_table(1, "R5");
    lock_cmd = 1; tick(); lock_cmd = 0;
    check("R7 relock", status, 2'b01);

    shift_bits(KEY_A, 0, KW-2);
    key_bit = KEY_A[KW-1]; key_shift_en = 1; key_update = 1; tick();
    key_shift_en = 0; key_update = 0;
    check("R5 no compare while shifting", status, 2'b01);
    pulse_update();
    check("R5 quiet update compares", status, 2'b10);

    rst = 1; tick(); rst = 0;
    check("R10 reset relocks", status, 2'b01);
    check("R10 enables", op_en, 4'h0);

    shift_bits(KEY_A, 0, KW-1); pulse_update();
    check("R5 unlocked again", status, 2'b10);
    perm_lock_cmd = 1; tick(); perm_lock_cmd = 0;
    check("R8 fused", status, 2'b11);
    check("R8 enables", op_en, 4'h0);
    shift_bits(KEY_A, 0, KW-1); pulse_update();
    check("R9 key cannot open", status, 2'b11);
    lock_cmd = 1; tick(); lock_cmd = 0;
    key_prog = 1; tick(); key_prog = 0;
    check("R9 commands ignored", status, 2'b11);
    run_table(0, "R9");
    rst = 1; tick(); rst = 0;
    check("R10 fuse survives reset", status, 2'b11);
    check("R9 enables after reset", op_en, 4'h0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule